// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test access port of a chip. A test clock and a mode-select line walk a sixteen-state controller through capture, shift and update phases for two register paths: an instruction path and a data path. A 4-bit instruction register picks the data register that sits between the serial input and the serial output. Two data registers are present. The first is a single-bit pass-through stage. The second is a 32-bit identification register holding a fixed code.

The controller decodes the capture, shift and update phases of both paths and drives them out as strobes, so that other test logic can hook into them. It also raises a flag that marks the test logic as inactive. There are two ways to force the controller back to its reset state. One is an asynchronous active-low reset pin, whose release is synchronised to the test clock. The other is five consecutive rising edges with mode-select high. On reset the identification opcode becomes the active instruction, so a tester can read the identification code at once, without loading an instruction first.

Top module: `tap_controller`

## Requirements
- R1: At most one of the seven state outputs (the six capture/shift/update strobes and logic_off) is high at any time, and none is high in Run-Test/Idle, the two Select states, Exit1, Pause or Exit2.
- R2: State changes happen on the rising test_clk edge and follow the sixteen-state graph for both values of mode_sel. Examples: Select-IR-Scan goes to Test-Logic-Reset on 1. Exit2 goes back to Shift on 0. Update goes to Select-DR-Scan on 1 and to Run-Test/Idle on 0.
- R3: Five consecutive rising edges with mode_sel high bring the controller to Test-Logic-Reset from any state.
- R4: tap_rst_n low forces Test-Logic-Reset at once, without a clock edge. It sets logic_off high and ser_oe low, and the controller stays in that state while the pin is low. The release takes effect after two rising test_clk edges.
- R5: In Test-Logic-Reset, logic_off is 1 and the active instruction is reloaded with the identification opcode 4'b0110. A data scan right after reset therefore returns the 32-bit identification code.
- R6: Capture-IR loads 4'b0001 into the instruction shift stage. In Shift-IR, ser_in enters at bit 3 and bit 0 leaves first on ser_out.
- R7: A shifted opcode becomes the active instruction only when the controller passes through Update-IR, and it selects the data register for every later data scan.
- R8: Opcode 4'b0110 selects the identification register. Every other opcode, 4'b1111 included, selects the single-bit pass-through register, which captures 0 and delays ser_in by one shift.
- R9: With the identification register selected, Capture-DR loads the 32-bit code (default 32'h5E1F_60A3, bit 0 = 1). The code shifts out bit 0 first, and ser_in enters at bit 31.
- R10: ser_out and ser_oe change on the falling test_clk edge. ser_oe is high exactly while the controller is in Shift-DR or Shift-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| test_clk | input | 1 | Test clock; state on rising edge, serial output on falling edge |
| tap_rst_n | input | 1 | Asynchronous active-low controller reset |
| mode_sel | input | 1 | Mode select steering the state graph |
| ser_in | input | 1 | Serial test data input |
| ser_out | output | 1 | Serial test data output |
| ser_oe | output | 1 | Output enable for ser_out |
| dr_capture | output | 1 | Controller is in Capture-DR |
| dr_shift | output | 1 | Controller is in Shift-DR |
| dr_update | output | 1 | Controller is in Update-DR |
| ir_capture | output | 1 | Controller is in Capture-IR |
| ir_shift | output | 1 | Controller is in Shift-IR |
| ir_update | output | 1 | Controller is in Update-IR |
| logic_off | output | 1 | Test logic disabled (Test-Logic-Reset) |

## Verification
The hardest cases to reach from the pins are the back edges deep in each branch: Exit2 returning to Shift, the Pause self-loops, and the five-cycle forced reset started from those deep states. Each one takes a specific mode_sel sequence of up to seven steps. The stimulus handles this with a path table. For every state it starts from Test-Logic-Reset, walks the shortest path to that state, applies each mode_sel value, and then applies five high cycles. A reference model in the bench checks every edge along the way. A second hard case is an asynchronous reset arriving in the middle of a data shift. The bench drops tap_rst_n between clock edges while in Shift-DR, checks that the outputs fall back at once, and then re-reads the identification code.

// File: rtl/tap_pkg.sv
package tap_pkg;

  typedef enum logic [3:0] {
    ST_RESET    = 4'd0,
    ST_IDLE     = 4'd1,
    ST_DR_SEL   = 4'd2,
    ST_DR_CAP   = 4'd3,
    ST_DR_SHIFT = 4'd4,
    ST_DR_EXIT1 = 4'd5,
    ST_DR_PAUSE = 4'd6,
    ST_DR_EXIT2 = 4'd7,
    ST_DR_UPD   = 4'd8,
    ST_IR_SEL   = 4'd9,
    ST_IR_CAP   = 4'd10,
    ST_IR_SHIFT = 4'd11,
    ST_IR_EXIT1 = 4'd12,
    ST_IR_PAUSE = 4'd13,
    ST_IR_EXIT2 = 4'd14,
    ST_IR_UPD   = 4'd15
  } tap_state_e;

  // Successor of a controller state for one mode-select value.
  function automatic tap_state_e tap_next(input tap_state_e cur, input logic sel);
    tap_state_e nxt;
    case (cur)
      ST_RESET:    nxt = sel ? ST_RESET    : ST_IDLE;
      ST_IDLE:     nxt = sel ? ST_DR_SEL   : ST_IDLE;
      ST_DR_SEL:   nxt = sel ? ST_IR_SEL   : ST_DR_CAP;
      ST_DR_CAP:   nxt = sel ? ST_DR_EXIT1 : ST_DR_SHIFT;
      ST_DR_SHIFT: nxt = sel ? ST_DR_EXIT1 : ST_DR_SHIFT;
      ST_DR_EXIT1: nxt = sel ? ST_DR_UPD   : ST_DR_PAUSE;
      ST_DR_PAUSE: nxt = sel ? ST_DR_EXIT2 : ST_DR_PAUSE;
      ST_DR_EXIT2: nxt = sel ? ST_DR_UPD   : ST_DR_SHIFT;
      ST_DR_UPD:   nxt = sel ? ST_DR_SEL   : ST_IDLE;
      ST_IR_SEL:   nxt = sel ? ST_RESET    : ST_IR_CAP;
      ST_IR_CAP:   nxt = sel ? ST_IR_EXIT1 : ST_IR_SHIFT;
      ST_IR_SHIFT: nxt = sel ? ST_IR_EXIT1 : ST_IR_SHIFT;
      ST_IR_EXIT1: nxt = sel ? ST_IR_UPD   : ST_IR_PAUSE;
      ST_IR_PAUSE: nxt = sel ? ST_IR_EXIT2 : ST_IR_PAUSE;
      ST_IR_EXIT2: nxt = sel ? ST_IR_UPD   : ST_IR_SHIFT;
      ST_IR_UPD:   nxt = sel ? ST_DR_SEL   : ST_IDLE;
      default:     nxt = ST_RESET;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/tap_rst_sync.sv
module tap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n = sync_q[STAGES-1];

endmodule

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  output tap_state_e state_o,
  output logic       cap_dr_o,
  output logic       sh_dr_o,
  output logic       upd_dr_o,
  output logic       cap_ir_o,
  output logic       sh_ir_o,
  output logic       upd_ir_o,
  output logic       idle_logic_o
);

  localparam int RUN_W      = 3;
  localparam int FORCE_RUNS = 5;

  tap_state_e state_q;
  tap_state_e state_d;

  always_comb begin
    state_d = tap_next(state_q, sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RESET;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o      = state_q;
  assign cap_dr_o     = (state_q == ST_DR_CAP);
  assign sh_dr_o      = (state_q == ST_DR_SHIFT);
  assign upd_dr_o     = (state_q == ST_DR_UPD);
  assign cap_ir_o     = (state_q == ST_IR_CAP);
  assign sh_ir_o      = (state_q == ST_IR_SHIFT);
  assign upd_ir_o     = (state_q == ST_IR_UPD);
  assign idle_logic_o = (state_q == ST_RESET);

  // Run length of consecutive high mode-select edges, for the checks below.
  logic [RUN_W-1:0] high_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      high_run_q <= '0;
    end else if (!sel) begin
      high_run_q <= '0;
    end else if (high_run_q != RUN_W'(FORCE_RUNS)) begin
      high_run_q <= high_run_q + 1'b1;
    end
  end

  // R3
  five_high_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (high_run_q == RUN_W'(FORCE_RUNS)) |-> (state_q == ST_RESET));

  // R2
  reset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RESET && sel) |=> (state_q == ST_RESET));

  // R2
  exit2_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DR_EXIT2 && !sel) |=> (state_q == ST_DR_SHIFT));

  // R1
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cap_dr_o, sh_dr_o, upd_dr_o, cap_ir_o, sh_ir_o, upd_ir_o, idle_logic_o}));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
#(
  parameter int           IR_W      = 4,
  parameter logic [IR_W-1:0] OP_IDCODE = 4'b0110,
  parameter logic [IR_W-1:0] CAP_PAT   = 4'b0001
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sin,
  input  tap_state_e      state,
  output logic [IR_W-1:0] active_o,
  output logic            sout_o
);

  logic [IR_W-1:0] sr_q, sr_d;
  logic [IR_W-1:0] act_q, act_d;
  logic            sr_en, act_en;

  always_comb begin
    sr_en  = 1'b0;
    act_en = 1'b0;
    sr_d   = sr_q;
    act_d  = act_q;
    case (state)
      ST_IR_CAP: begin
        sr_en = 1'b1;
        sr_d  = CAP_PAT;
      end
      ST_IR_SHIFT: begin
        sr_en = 1'b1;
        sr_d  = {sin, sr_q[IR_W-1:1]};
      end
      ST_IR_UPD: begin
        act_en = 1'b1;
        act_d  = sr_q;
      end
      ST_RESET: begin
        act_en = 1'b1;
        act_d  = OP_IDCODE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (sr_en) begin
      sr_q <= sr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= OP_IDCODE;
    end else if (act_en) begin
      act_q <= act_d;
    end
  end

  assign active_o = act_q;
  assign sout_o   = sr_q[0];

  // R7
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IR_UPD && state != ST_RESET) |=> $stable(act_q));

  // R6
  ir_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IR_CAP) |=> (sr_q == CAP_PAT));

  // R5
  ir_reset_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RESET) |=> (act_q == OP_IDCODE));

endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import tap_pkg::*;
#(
  parameter int              IR_W      = 4,
  parameter int              ID_W      = 32,
  parameter logic [ID_W-1:0] ID_VALUE  = 32'h5E1F_60A3,
  parameter logic [IR_W-1:0] OP_IDCODE = 4'b0110
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sin,
  input  tap_state_e      state,
  input  logic [IR_W-1:0] instr,
  output logic            sout_o
);

  logic            sel_id;
  logic            walk;
  logic            byp_q, byp_d, byp_en;
  logic [ID_W-1:0] id_q, id_d;
  logic            id_en;

  assign sel_id = (instr == OP_IDCODE);
  assign walk   = (state == ST_DR_CAP) || (state == ST_DR_SHIFT);

  always_comb begin
    byp_en = walk && !sel_id;
    id_en  = walk && sel_id;
    if (state == ST_DR_CAP) begin
      byp_d = 1'b0;
      id_d  = ID_VALUE;
    end else begin
      byp_d = sin;
      id_d  = {sin, id_q[ID_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byp_q <= 1'b0;
    end else if (byp_en) begin
      byp_q <= byp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q <= '0;
    end else if (id_en) begin
      id_q <= id_d;
    end
  end

  assign sout_o = sel_id ? id_q[0] : byp_q;

  // R8
  bypass_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DR_CAP && !sel_id) |=> !byp_q);

  // R9
  id_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DR_CAP && sel_id) |=> (id_q == ID_VALUE));

endmodule

// File: rtl/tap_controller.sv
module tap_controller
  import tap_pkg::*;
#(
  parameter int                 IR_W      = 4,
  parameter int                 ID_W      = 32,
  parameter logic [ID_W-1:0]    ID_VALUE  = 32'h5E1F_60A3,
  parameter logic [IR_W-1:0]    OP_IDCODE = 4'b0110,
  parameter logic [IR_W-1:0]    CAP_PAT   = 4'b0001,
  parameter int                 SYNC_LEN  = 2
) (
  input  logic test_clk,
  input  logic tap_rst_n,
  input  logic mode_sel,
  input  logic ser_in,
  output logic ser_out,
  output logic ser_oe,
  output logic dr_capture,
  output logic dr_shift,
  output logic dr_update,
  output logic ir_capture,
  output logic ir_shift,
  output logic ir_update,
  output logic logic_off
);

  logic            rst_n;
  tap_state_e      state;
  logic [IR_W-1:0] instr;
  logic            ir_sout;
  logic            dr_sout;
  logic            out_q, oe_q;
  logic            out_d, oe_d;

  tap_rst_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk    (test_clk),
    .arst_n (tap_rst_n),
    .rst_n  (rst_n)
  );

  tap_fsm u_fsm (
    .clk          (test_clk),
    .rst_n        (rst_n),
    .sel          (mode_sel),
    .state_o      (state),
    .cap_dr_o     (dr_capture),
    .sh_dr_o      (dr_shift),
    .upd_dr_o     (dr_update),
    .cap_ir_o     (ir_capture),
    .sh_ir_o      (ir_shift),
    .upd_ir_o     (ir_update),
    .idle_logic_o (logic_off)
  );

  tap_ir #(
    .IR_W      (IR_W),
    .OP_IDCODE (OP_IDCODE),
    .CAP_PAT   (CAP_PAT)
  ) u_ir (
    .clk      (test_clk),
    .rst_n    (rst_n),
    .sin      (ser_in),
    .state    (state),
    .active_o (instr),
    .sout_o   (ir_sout)
  );

  tap_dr #(
    .IR_W      (IR_W),
    .ID_W      (ID_W),
    .ID_VALUE  (ID_VALUE),
    .OP_IDCODE (OP_IDCODE)
  ) u_dr (
    .clk    (test_clk),
    .rst_n  (rst_n),
    .sin    (ser_in),
    .state  (state),
    .instr  (instr),
    .sout_o (dr_sout)
  );

  // Serial output retimed to the falling edge.
  always_comb begin
    oe_d  = dr_shift || ir_shift;
    out_d = ir_shift ? ir_sout : (dr_shift ? dr_sout : 1'b0);
  end

  always_ff @(negedge test_clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      out_q <= out_d;
      oe_q  <= oe_d;
    end
  end

  assign ser_out = out_q;
  assign ser_oe  = oe_q;

  // R10
  oe_window_chk: assert property (@(posedge test_clk) disable iff (!rst_n)
    ser_oe == (dr_shift || ir_shift));

  // R4
  reset_outputs_chk: assert property (@(posedge test_clk)
    !rst_n |-> (logic_off && !ser_oe));

endmodule

// File: tb/tap_controller_test.sv
module tap_controller_test;

  localparam logic [31:0] ID   = 32'h5E1F_60A3;
  localparam logic [3:0]  OPID = 4'b0110;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic trst_n, tms, tdi;
  logic ser_out, ser_oe, dr_capture, dr_shift, dr_update;
  logic ir_capture, ir_shift, ir_update, logic_off;

  tap_controller uut (
    .test_clk   (clk),
    .tap_rst_n  (trst_n),
    .mode_sel   (tms),
    .ser_in     (tdi),
    .ser_out    (ser_out),
    .ser_oe     (ser_oe),
    .dr_capture (dr_capture),
    .dr_shift   (dr_shift),
    .dr_update  (dr_update),
    .ir_capture (ir_capture),
    .ir_shift   (ir_shift),
    .ir_update  (ir_update),
    .logic_off  (logic_off)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference model: state numbers 0..15 are the bench's own numbering.
  int          ms;
  logic [3:0]  m_irsr, m_act;
  logic [31:0] m_id;
  logic        m_byp;
  logic        last_out;

  function automatic int mnext(int s, logic t);
    case (s)
      0: return t ? 0 : 1;    1: return t ? 2 : 1;
      2: return t ? 9 : 3;    3: return t ? 5 : 4;
      4: return t ? 5 : 4;    5: return t ? 8 : 6;
      6: return t ? 7 : 6;    7: return t ? 8 : 4;
      8: return t ? 2 : 1;    9: return t ? 0 : 10;
      10: return t ? 12 : 11; 11: return t ? 12 : 11;
      12: return t ? 15 : 13; 13: return t ? 14 : 13;
      14: return t ? 15 : 11; default: return t ? 2 : 1;
    endcase
  endfunction

  function automatic int path_len(int s);
    int l [16] = '{0, 1, 2, 3, 4, 4, 5, 6, 5, 3, 4, 5, 5, 6, 7, 6};
    return l[s];
  endfunction

  function automatic logic [7:0] path_bits(int s);
    logic [7:0] b [16] = '{8'h00, 8'h00, 8'h02, 8'h02, 8'h02, 8'h0A, 8'h0A, 8'h2A,
                           8'h1A, 8'h06, 8'h06, 8'h06, 8'h16, 8'h16, 8'h56, 8'h36};
    return b[s];
  endfunction

  function automatic logic [6:0] exp_strobes(int s);
    return {s == 0, s == 3, s == 4, s == 8, s == 10, s == 11, s == 15};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick(input logic t, input logic d);
    logic [6:0] got;
    logic       eoe, eout;
    tms = t;
    tdi = d;
    @(posedge clk);
    case (ms)
      10: m_irsr = 4'b0001;
      11: m_irsr = {d, m_irsr[3:1]};
      15: m_act  = m_irsr;
      0:  m_act  = OPID;
      3:  if (m_act == OPID) m_id = ID; else m_byp = 1'b0;
      4:  if (m_act == OPID) m_id = {d, m_id[31:1]}; else m_byp = d;
      default: ;
    endcase
    ms = mnext(ms, t);
    #1;
    got = {logic_off, dr_capture, dr_shift, dr_update, ir_capture, ir_shift, ir_update};
    check(got == exp_strobes(ms), "R2", "state strobes", 32'(got), 32'(exp_strobes(ms)));
    check($countones(got) <= 1, "R1", "strobe count", 32'($countones(got)), 32'd1);
    @(negedge clk);
    #1;
    eoe  = (ms == 4) || (ms == 11);
    eout = (ms == 11) ? m_irsr[0] : ((m_act == OPID) ? m_id[0] : m_byp);
    check(ser_oe == eoe, "R10", "ser_oe", 32'(ser_oe), 32'(eoe));
    if (eoe) begin
      if (ms == 11)
        check(ser_out == eout, "R6", "ir ser_out", 32'(ser_out), 32'(eout));
      else if (m_act == OPID)
        check(ser_out == eout, "R9", "id ser_out", 32'(ser_out), 32'(eout));
      else
        check(ser_out == eout, "R8", "bypass ser_out", 32'(ser_out), 32'(eout));
    end
    last_out = ser_out;
  endtask

  task automatic force_reset_by_ones();
    repeat (5) tick(1'b1, 1'b0);
    check(logic_off == 1'b1, "R3", "logic_off after five highs", 32'(logic_off), 32'd1);
  endtask

  task automatic goto_state(input int s);
    logic [7:0] b;
    b = path_bits(s);
    for (int i = 0; i < path_len(s); i++) tick(b[i], 1'b0);
  endtask

  task automatic pin_reset();
    trst_n = 1'b0;
    #2;
    ms    = 0;
    m_act = OPID;
    check(logic_off == 1'b1, "R4", "logic_off on pin reset", 32'(logic_off), 32'd1);
    check(ser_oe == 1'b0, "R4", "ser_oe on pin reset", 32'(ser_oe), 32'd0);
    tms = 1'b0;
    @(posedge clk);
    #1;
    check(logic_off == 1'b1, "R4", "held while pin low", 32'(logic_off), 32'd1);
    @(negedge clk);
    #1;
    trst_n = 1'b1;
    repeat (3) tick(1'b1, 1'b0);
  endtask

  // From Run-Test/Idle: scan n data bits, return what appeared on ser_out.
  task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] got);
    got = '0;
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    got[0] = last_out;
    for (int i = 1; i < n; i++) begin
      tick(1'b0, din[i-1]);
      got[i] = last_out;
    end
    tick(1'b1, din[n-1]);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
  endtask

  task automatic load_ir(input logic [3:0] op, output logic [3:0] got);
    got = '0;
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    got[0] = last_out;
    for (int i = 1; i < 4; i++) begin
      tick(1'b0, op[i-1]);
      got[i] = last_out;
    end
    tick(1'b1, op[3]);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    logic [3:0]  ir_rd;
    trst_n = 1'b0;
    tms    = 1'b1;
    tdi    = 1'b0;
    ms     = 0;
    m_act  = OPID;
    m_irsr = '0;
    m_id   = '0;
    m_byp  = 1'b0;
    last_out = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(logic_off == 1'b1, "R4", "reset logic_off", 32'(logic_off), 32'd1);
    check(ser_oe == 1'b0, "R4", "reset ser_oe", 32'(ser_oe), 32'd0);
    check({dr_capture, dr_shift, dr_update, ir_capture, ir_shift, ir_update} == 6'd0,
          "R1", "reset strobes", 32'({dr_capture, dr_shift, dr_update, ir_capture, ir_shift, ir_update}), 32'd0);
    @(negedge clk);
    #1;
    trst_n = 1'b1;
    repeat (3) tick(1'b1, 1'b0);

    // Identification code straight after reset.
    tick(1'b0, 1'b0);
    scan_dr(32, 32'h0, rd);
    check(rd == ID, "R5", "id read after reset", rd, ID);
    check(rd[0] == 1'b1, "R9", "id bit 0", 32'(rd[0]), 32'd1);

    // Pass-through with the all-ones opcode.
    load_ir(4'b1111, ir_rd);
    check(ir_rd == 4'b0001, "R6", "ir capture pattern", 32'(ir_rd), 32'h1);
    scan_dr(4, 32'hB, rd);
    check(rd[3:0] == 4'b0110, "R8", "bypass ones opcode", 32'(rd[3:0]), 32'h6);

    // Unknown opcode also selects pass-through.
    load_ir(4'b1010, ir_rd);
    check(ir_rd == 4'b0001, "R6", "ir capture pattern again", 32'(ir_rd), 32'h1);
    scan_dr(4, 32'h5, rd);
    check(rd[3:0] == 4'b1010, "R8", "bypass unknown opcode", 32'(rd[3:0]), 32'hA);

    // Loading the identification opcode takes effect after update.
    load_ir(OPID, ir_rd);
    scan_dr(32, 32'hC3A5_0F96, rd);
    check(rd == ID, "R7", "id after loading opcode", rd, ID);

    // Test-Logic-Reset reloads the identification opcode.
    load_ir(4'b1111, ir_rd);
    force_reset_by_ones();
    tick(1'b0, 1'b0);
    scan_dr(32, 32'hFFFF_FFFF, rd);
    check(rd == ID, "R5", "id after forced reset", rd, ID);

    // Every transition for both mode-select values, then forced reset.
    for (int s = 0; s < 16; s++) begin
      for (int t = 0; t < 2; t++) begin
        force_reset_by_ones();
        goto_state(s);
        tick(t[0], t[0]);
        force_reset_by_ones();
      end
    end

    // Asynchronous pin reset in the middle of a data shift.
    tick(1'b0, 1'b0);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b1);
    pin_reset();
    tick(1'b0, 1'b0);
    scan_dr(32, 32'h0, rd);
    check(rd == ID, "R4", "id after mid-shift pin reset", rd, ID);

    finish_run();
  end

endmodule